// File: doc/BRIEF.md
# PDM Threshold DAC Modulator

This block turns a 12-bit code into a single-bit stream whose fraction of ones follows the code. An analog RC filter outside the block smooths the stream into a threshold voltage. A parameter sets the number of channels. Every channel has its own code register and its own stream, plus a pin output that carries the stream only when that channel's pin-routing bit is set.

A small register interface sets up the block. One shared control word holds a global on bit that starts or stops all modulators at once. Each channel also has a control word, which holds a run-enable bit and a pin-routing bit, and a code word. A written code outside the legal window of 0x0CD to 0xF32 is saturated to the nearer limit, so the stream density always stays between about 5% and 95%.

Each modulator is a first-order sigma-delta accumulator. A code change loads into a running modulator only when its accumulator wraps. Stopping a modulator clears its accumulator, so a restarted channel always begins from zero.

Top module: `pdm_thresh_dac`

## Requirements
- R1: After reset, the global word (address 0), both channel control words (address 1) and the pin outputs read or drive 0, every stream is low, and every code word (address 2) reads 0x0CD.
- R2: A code write (address 2, bits 11:0) below 0x0CD is stored as 0x0CD, and one above 0xF32 is stored as 0xF32. A code inside the window is stored unchanged. Read data bits 15:12 are 0.
- R3: A channel's stream stays low whenever its run-enable bit (address 1, bit 15) or the global on bit (address 0, bit 15) is clear.
- R4: While a channel runs with a fixed code C, every 4096 consecutive clocks of its stream contain exactly C ones.
- R5: A channel's pin output carries its stream while the pin-routing bit (address 1, bit 9) is set, and is held low while that bit is clear.
- R6: Stopping a channel clears its accumulator. After a restart with code C, the first one appears on update ceil(4096/C): update 20 for 0x0CD and update 2 for 0xF32.
- R7: A code written to a running channel is applied only on a clock where the accumulator wraps. After that, the density follows the new code exactly.
- R8: Clearing the global on bit stops all channels at once. Setting it again restarts every enabled channel from a zero accumulator.
- R9: Code 0x4D9 gives 1241 ones per 4096 clocks, a density of about 0.303.
- R10: Channels running different codes at the same time each produce the density of their own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 2 | 0 global word, 1 channel control, 2 channel code |
| reg_ch | input | CH_W | Channel selected for addresses 1 and 2 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| stream_out | output | NUM_CH | Modulated stream for each channel |
| pin_out | output | NUM_CH | Stream gated by each channel's pin-routing bit |

## Verification
The assertions assume that writes name an existing channel. They also assume that the code register is the only source of a modulator's code, so a clamped value is always inside the window. On that basis they check three things: a stopped modulator is quiet, its accumulator is cleared, and its applied code changes only on a wrap or while it is stopped. The stimulus writes only to channels 0 and 1 and always addresses registers 0 to 2. It never changes a code inside a measured window, so every window count can be compared exactly against the code.

// File: rtl/pdm_dac_pkg.sv
package pdm_dac_pkg;
  localparam int REG_W   = 16;
  localparam int ON_BIT  = 15;
  localparam int RUN_BIT = 15;
  localparam int PIN_BIT = 9;

  typedef enum logic [1:0] {
    ADDR_GLOBAL = 2'd0,
    ADDR_CTRL   = 2'd1,
    ADDR_CODE   = 2'd2,
    ADDR_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pdm_rst_sync.sv
module pdm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pdm_code_clamp.sv
module pdm_code_clamp #(
  parameter int          DATA_W   = 12,
  parameter int unsigned CODE_MIN = 32'h0CD,
  parameter int unsigned CODE_MAX = 32'hF32
) (
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] sat
);
  localparam logic [DATA_W-1:0] LO = CODE_MIN[DATA_W-1:0];
  localparam logic [DATA_W-1:0] HI = CODE_MAX[DATA_W-1:0];

  always_comb begin
    if (raw < LO)      sat = LO;
    else if (raw > HI) sat = HI;
    else               sat = raw;
  end
endmodule

// File: rtl/pdm_dac_regs.sv
module pdm_dac_regs
  import pdm_dac_pkg::*;
#(
  parameter int          NUM_CH   = 2,
  parameter int          DATA_W   = 12,
  parameter int          CH_W     = 1,
  parameter int unsigned CODE_MIN = 32'h0CD,
  parameter int unsigned CODE_MAX = 32'hF32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [1:0]               addr,
  input  logic [CH_W-1:0]          ch,
  input  logic [REG_W-1:0]         wdata,
  output logic [REG_W-1:0]         rdata,
  output logic                     global_on,
  output logic [NUM_CH-1:0]        run_en,
  output logic [NUM_CH-1:0]        pin_en,
  output logic [NUM_CH*DATA_W-1:0] code_flat
);
  logic                    gon_q, gon_d;
  logic [NUM_CH-1:0]       run_q, run_d;
  logic [NUM_CH-1:0]       pin_q, pin_d;
  logic [DATA_W-1:0]       code_q [NUM_CH];
  logic [DATA_W-1:0]       code_d [NUM_CH];
  logic [DATA_W-1:0]       wr_sat;
  logic                    ch_ok;

  pdm_code_clamp #(
    .DATA_W  (DATA_W),
    .CODE_MIN(CODE_MIN),
    .CODE_MAX(CODE_MAX)
  ) u_clamp (
    .raw(wdata[DATA_W-1:0]),
    .sat(wr_sat)
  );

  assign ch_ok = (32'(ch) < NUM_CH);

  always_comb begin
    gon_d  = gon_q;
    run_d  = run_q;
    pin_d  = pin_q;
    code_d = code_q;
    case (reg_addr_e'(addr))
      ADDR_GLOBAL: gon_d = wdata[ON_BIT];
      ADDR_CTRL: if (ch_ok) begin
        run_d[ch] = wdata[RUN_BIT];
        pin_d[ch] = wdata[PIN_BIT];
      end
      ADDR_CODE: if (ch_ok) code_d[ch] = wr_sat;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gon_q <= 1'b0;
      run_q <= '0;
      pin_q <= '0;
      for (int i = 0; i < NUM_CH; i++) code_q[i] <= CODE_MIN[DATA_W-1:0];
    end else if (wr) begin
      gon_q  <= gon_d;
      run_q  <= run_d;
      pin_q  <= pin_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      ADDR_GLOBAL: rdata[ON_BIT] = gon_q;
      ADDR_CTRL: if (ch_ok) begin
        rdata[RUN_BIT] = run_q[ch];
        rdata[PIN_BIT] = pin_q[ch];
      end
      ADDR_CODE: if (ch_ok) rdata[DATA_W-1:0] = code_q[ch];
      default: ;
    endcase
  end

  assign global_on = gon_q;
  assign run_en    = run_q;
  assign pin_en    = pin_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign code_flat[g*DATA_W +: DATA_W] = code_q[g];
  end
endmodule

// File: rtl/pdm_sd_core.sv
module pdm_sd_core #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DATA_W-1:0] code_in,
  output logic              stream,
  output logic [DATA_W-1:0] active_code,
  output logic [DATA_W-1:0] acc
);
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] act_q, act_d;
  logic              bit_q, bit_d;
  logic [DATA_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, act_q};

  always_comb begin
    if (!run) begin
      acc_d = '0;
      act_d = code_in;
      bit_d = 1'b0;
    end else begin
      acc_d = sum[DATA_W-1:0];
      bit_d = sum[DATA_W];
      act_d = sum[DATA_W] ? code_in : act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      act_q <= '0;
      bit_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      act_q <= act_d;
      bit_q <= bit_d;
    end
  end

  assign stream      = bit_q;
  assign active_code = act_q;
  assign acc         = acc_q;
endmodule

// File: rtl/pdm_thresh_dac.sv
module pdm_thresh_dac
  import pdm_dac_pkg::*;
#(
  parameter  int          NUM_CH      = 2,
  parameter  int          DATA_W      = 12,
  parameter  int unsigned CODE_MIN    = 32'h0CD,
  parameter  int unsigned CODE_MAX    = 32'hF32,
  parameter  int          SYNC_STAGES = 2,
  localparam int          CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [CH_W-1:0]   reg_ch,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [NUM_CH-1:0] stream_out,
  output logic [NUM_CH-1:0] pin_out
);
  localparam int FLAT_W = NUM_CH * DATA_W;

  logic              rst_sn;
  logic              global_on;
  logic [NUM_CH-1:0] run_en;
  logic [NUM_CH-1:0] pin_en;
  logic [NUM_CH-1:0] run_vec;
  logic [FLAT_W-1:0] code_flat;
  logic [FLAT_W-1:0] active_flat;
  logic [FLAT_W-1:0] acc_flat;

  pdm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sn)
  );

  pdm_dac_regs #(
    .NUM_CH  (NUM_CH),
    .DATA_W  (DATA_W),
    .CH_W    (CH_W),
    .CODE_MIN(CODE_MIN),
    .CODE_MAX(CODE_MAX)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .ch       (reg_ch),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .global_on(global_on),
    .run_en   (run_en),
    .pin_en   (pin_en),
    .code_flat(code_flat)
  );

  assign run_vec = run_en & {NUM_CH{global_on}};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pdm_sd_core #(.DATA_W(DATA_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_sn),
      .run        (run_vec[g]),
      .code_in    (code_flat[g*DATA_W +: DATA_W]),
      .stream     (stream_out[g]),
      .active_code(active_flat[g*DATA_W +: DATA_W]),
      .acc        (acc_flat[g*DATA_W +: DATA_W])
    );
  end

  assign pin_out = stream_out & pin_en;
endmodule

// File: rtl/pdm_thresh_dac_chk.sv
module pdm_thresh_dac_chk #(
  parameter int          NUM_CH   = 2,
  parameter int          DATA_W   = 12,
  parameter int unsigned CODE_MIN = 32'h0CD,
  parameter int unsigned CODE_MAX = 32'hF32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CH-1:0]        run,
  input logic [NUM_CH-1:0]        stream,
  input logic [NUM_CH*DATA_W-1:0] code_flat,
  input logic [NUM_CH*DATA_W-1:0] active_flat,
  input logic [NUM_CH*DATA_W-1:0] acc_flat
);
  localparam logic [DATA_W-1:0] LO = CODE_MIN[DATA_W-1:0];
  localparam logic [DATA_W-1:0] HI = CODE_MAX[DATA_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R2
    code_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_flat[g*DATA_W +: DATA_W] >= LO) && (code_flat[g*DATA_W +: DATA_W] <= HI));

    // R3
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run[g] |=> !stream[g]);

    // R6
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run[g] |=> (acc_flat[g*DATA_W +: DATA_W] == '0));

    // R7
    load_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_flat[g*DATA_W +: DATA_W]) |-> (stream[g] || !$past(run[g])));
  end
endmodule

bind pdm_thresh_dac pdm_thresh_dac_chk #(
  .NUM_CH  (NUM_CH),
  .DATA_W  (DATA_W),
  .CODE_MIN(CODE_MIN),
  .CODE_MAX(CODE_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .run        (run_vec),
  .stream     (stream_out),
  .code_flat  (code_flat),
  .active_flat(active_flat),
  .acc_flat   (acc_flat)
);

// File: tb/sim_pdm_thresh_dac.sv
`timescale 1ns/1ps
module sim_pdm_thresh_dac;
  localparam int NUM_CH = 2;
  localparam int WIN    = 4096;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [0:0]  reg_ch;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [1:0]  stream_out;
  logic [1:0]  pin_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    int    ch;
    int    exp_str;
    int    exp_pin;
    string req;
  } item_t;
  item_t exp_q[$];

  pdm_thresh_dac #(.NUM_CH(NUM_CH)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_ch    (reg_ch),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .stream_out(stream_out),
    .pin_out   (pin_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int ch, input int data);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = 2'(addr);
    reg_ch    = 1'(ch);
    reg_wdata = 16'(data);
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd_chk(input int addr, input int ch, input int exp, input string req);
    @(negedge clk);
    reg_addr = 2'(addr);
    reg_ch   = 1'(ch);
    #1;
    chk(reg_rdata == 16'(exp), req, int'(reg_rdata), exp);
  endtask

  // scoreboard driver side: queue an expected window count, wait until consumed
  task automatic expect_window(input int ch, input int es, input int ep, input string req);
    item_t it;
    it.ch = ch; it.exp_str = es; it.exp_pin = ep; it.req = req;
    exp_q.push_back(it);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // quiet window: count stream and pin ones over n cycles
  task automatic count_ones(input int ch, input int n, output int s, output int p);
    s = 0; p = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s += int'(stream_out[ch]);
      p += int'(pin_out[ch]);
    end
  endtask

  // monitor side
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        item_t it;
        int s, p;
        it = exp_q[0];
        s = 0; p = 0;
        for (int k = 0; k < WIN; k++) begin
          if (k != 0) @(negedge clk);
          s += int'(stream_out[it.ch]);
          p += int'(pin_out[it.ch]);
        end
        chk(s == it.exp_str, {it.req, " stream ones"}, s, it.exp_str);
        chk(p == it.exp_pin, {it.req, " pin ones"}, p, it.exp_pin);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int s, p, s1, p1, f0, f1;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_ch = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(0, 0, 16'h0000, "R1 global word");
    rd_chk(1, 0, 16'h0000, "R1 ctrl ch0");
    rd_chk(1, 1, 16'h0000, "R1 ctrl ch1");
    rd_chk(2, 0, 16'h00CD, "R1 code ch0");
    rd_chk(2, 1, 16'h00CD, "R1 code ch1");
    chk(stream_out == 2'b00 && pin_out == 2'b00, "R1 outputs", int'({stream_out, pin_out}), 0);

    // R2 saturation
    wr(2, 0, 16'h0010); rd_chk(2, 0, 16'h00CD, "R2 low clamp");
    wr(2, 0, 16'h00CC); rd_chk(2, 0, 16'h00CD, "R2 just below");
    wr(2, 0, 16'h00CD); rd_chk(2, 0, 16'h00CD, "R2 low edge");
    wr(2, 0, 16'hFFFF); rd_chk(2, 0, 16'h0F32, "R2 high clamp");
    wr(2, 0, 16'h0F33); rd_chk(2, 0, 16'h0F32, "R2 just above");
    wr(2, 1, 16'h0F32); rd_chk(2, 1, 16'h0F32, "R2 high edge");
    wr(2, 0, 16'h04D9); rd_chk(2, 0, 16'h04D9, "R2 in range");

    // R3 enable without global on
    wr(1, 0, 16'h8000);
    count_ones(0, 300, s, p);
    chk(s == 0, "R3 global off quiet", s, 0);

    // R9 density of 0x4D9, pin routing off (R5)
    wr(0, 0, 16'h8000);
    expect_window(0, 1241, 0, "R9 code 0x4D9 no pin");

    // R5 pin routing on
    wr(1, 0, 16'h8200);
    expect_window(0, 1241, 1241, "R5 pin routed");

    // R4 / R10 two channels together
    wr(1, 1, 16'h8200);
    expect_window(1, 3890, 3890, "R4 R10 ch1 0xF32");
    expect_window(0, 1241, 1241, "R10 ch0 alongside");

    // R7 code change on running channel
    wr(2, 0, 16'h00CD);
    repeat (50) @(negedge clk);
    expect_window(0, 205, 205, "R7 new code");

    // R3 per-channel disable, then R6 restart timing
    wr(1, 0, 16'h0200);
    count_ones(0, 50, s, p);
    chk(s == 0 && p == 0, "R3 ch0 disabled", s + p, 0);
    wr(1, 0, 16'h8200);
    f0 = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (f0 == 0 && stream_out[0]) f0 = k;
    end
    chk(f0 == 20, "R6 first one after restart", f0, 20);

    // R8 global off stops all; global on restarts from zero
    wr(0, 0, 16'h0000);
    count_ones(0, 50, s, p);
    count_ones(1, 50, s1, p1);
    chk(s + s1 == 0, "R8 all quiet", s + s1, 0);
    wr(0, 0, 16'h8000);
    f0 = 0; f1 = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (f0 == 0 && stream_out[0]) f0 = k;
      if (f1 == 0 && stream_out[1]) f1 = k;
    end
    chk(f0 == 20, "R8 R6 ch0 restart", f0, 20);
    chk(f1 == 2, "R8 R6 ch1 restart", f1, 2);

    // R5 pin held low while stream runs
    wr(1, 1, 16'h8000);
    count_ones(1, 300, s, p);
    chk(p == 0, "R5 pin low", p, 0);
    chk(s > 0, "R5 stream still running", s, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule